// File: doc/BRIEF.md
# USB Start-of-Frame Tick Generator

This block paces the frames of a USB host controller. It keeps a 14-bit frame number, advances it once per frame tick, and flags each tick in a status bit that feeds the controller's interrupt line. A cycle-count parameter sets the spacing of ticks. A single-cycle start strobe from the port logic arms the generator. The port logic raises this strobe when the port has been powered with a device attached. The first tick then fires in the same cycle as the strobe, and after that each tick follows the previous one by exactly one period.

Software reaches the block through a small word-wide register port. One address returns the frame word: the frame number in the low bits, with a fixed identification value packed into the upper half. That word is read-only, and writes to it change nothing. A second address holds the tick-pending status bit, which software clears by writing one to it. The interrupt output is the pending bit gated by an enable pin. Everything on the port is plain control and status; there is no streamed data, so no valid/ready handshake is involved.

Top module: `usb_sof_gen`

## Requirements
- R1: After reset the frame number is 0, the pending bit is 0, `irq_o` is 0, and no tick occurs until the first start strobe.
- R2: Each tick increments the frame number by exactly 1 at the following clock edge, and 14'h3FFF is followed by 0; without a tick the frame number holds.
- R3: A write to the frame word address (4'h0) leaves the frame number unchanged, whatever data is written.
- R4: A read at address 4'h0 returns 16'h3210 in bits 31:16, zero in bits 15:14 and the frame number in bits 13:0.
- R5: Each tick sets the pending bit. The pending bit reads as bit 3 of address 4'h4, with all other bits zero. It stays set until a write to 4'h4 with data bit 3 equal to 1. Writes with bit 3 equal to 0 leave it set. When a tick and a clearing write fall in the same cycle, the bit remains set.
- R6: Once armed, consecutive ticks are exactly `PERIOD_CYC` clock cycles apart when no start strobe intervenes.
- R7: A start strobe produces a tick in the same cycle, so the frame number has advanced after that edge, and the period count restarts from that tick. A strobe held high ticks every cycle.
- R8: `irq_o` equals the pending bit ANDed with `irq_en_i`, combinationally.
- R9: A read at any address other than 4'h0 and 4'h4 returns 0, and a write there changes neither the frame number nor the pending bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Arm strobe from the port logic; forces an immediate tick |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Register address for both read and write |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, combinational on `reg_addr_i` |
| irq_en_i | input | 1 | Enable for the tick interrupt |
| irq_o | output | 1 | Tick interrupt request |

## Verification
The assertions assume that `start_i`, the register port and `irq_en_i` are clean, synchronous levels sampled at the rising edge. They place no limit on how often a start strobe may come, and they allow a start to land in the same cycle as a period expiry. The period assertions count cycles from the last tick and exempt ticks caused by a start. The bench changes inputs only on the falling edge. Its random mix covers rare start strobes, reads and writes at mapped and unmapped addresses, and random write data. Directed runs add a held start strobe long enough to wrap the frame number, and a clearing write made in the same cycle as a tick.

// File: rtl/usb_sof_pkg.sv
package usb_sof_pkg;
  localparam int          REG_W        = 32;
  localparam int          ADDR_W       = 4;
  localparam int          FRAME_W      = 14;
  localparam logic [15:0] FRAME_TAG    = 16'h3210;
  localparam logic [ADDR_W-1:0] ADDR_FRAME = 4'h0;
  localparam logic [ADDR_W-1:0] ADDR_STAT  = 4'h4;
  localparam int          STAT_SOF_BIT = 3;
  localparam logic [REG_W-1:0] STAT_MASK = REG_W'(1) << STAT_SOF_BIT;
endpackage

// File: rtl/sof_period_timer.sv
module sof_period_timer #(
  parameter int PERIOD_CYC = 5000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic tick_o
);
  localparam int CNT_W = (PERIOD_CYC > 1) ? $clog2(PERIOD_CYC) : 1;

  logic running_q;

  generate
    if (PERIOD_CYC <= 1) begin : g_every
      assign tick_o = start_i | running_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       running_q <= 1'b0;
        else if (start_i) running_q <= 1'b1;
      end
    end else begin : g_count
      localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD_CYC - 1);
      logic [CNT_W-1:0] cnt_q;
      logic             expire;

      assign expire = running_q && (cnt_q == LAST);
      assign tick_o = start_i | expire;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          running_q <= 1'b0;
          cnt_q     <= '0;
        end else if (tick_o) begin
          running_q <= 1'b1;
          cnt_q     <= '0;
        end else if (running_q) begin
          cnt_q     <= cnt_q + CNT_W'(1);
        end
      end
    end
  endgenerate
endmodule

// File: rtl/sof_frame_counter.sv
module sof_frame_counter #(
  parameter int FRAME_W = 14
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick_i,
  output logic [FRAME_W-1:0] frame_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      frame_o <= '0;
    else if (tick_i) frame_o <= frame_o + FRAME_W'(1);
  end
endmodule

// File: rtl/sof_pend_flag.sv
module sof_pend_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic pend_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     pend_o <= 1'b0;
    else if (set_i) pend_o <= 1'b1;
    else if (clr_i) pend_o <= 1'b0;
  end
endmodule

// File: rtl/usb_sof_gen.sv
module usb_sof_gen
  import usb_sof_pkg::*;
#(
  parameter int PERIOD_CYC = 5000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              reg_wr_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [REG_W-1:0]  reg_wdata_i,
  output logic [REG_W-1:0]  reg_rdata_o,
  input  logic              irq_en_i,
  output logic              irq_o
);
  localparam int PAD_W = 16 - FRAME_W;

  logic               sof_tick;
  logic [FRAME_W-1:0] frame_q;
  logic               sof_pend;
  logic               stat_clr;

  sof_period_timer #(.PERIOD_CYC(PERIOD_CYC)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .tick_o  (sof_tick)
  );

  sof_frame_counter #(.FRAME_W(FRAME_W)) u_frame (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick_i  (sof_tick),
    .frame_o (frame_q)
  );

  // write-one-to-clear on the status word; the frame word has no write path
  assign stat_clr = reg_wr_i && (reg_addr_i == ADDR_STAT)
                    && |(reg_wdata_i & STAT_MASK);

  sof_pend_flag u_pend (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (sof_tick),
    .clr_i  (stat_clr),
    .pend_o (sof_pend)
  );

  always_comb begin
    unique case (reg_addr_i)
      ADDR_FRAME: reg_rdata_o = {FRAME_TAG, {PAD_W{1'b0}}, frame_q};
      ADDR_STAT:  reg_rdata_o = sof_pend ? STAT_MASK : '0;
      default:    reg_rdata_o = '0;
    endcase
  end

  assign irq_o = sof_pend & irq_en_i;
endmodule

// File: rtl/usb_sof_gen_chk.sv
module usb_sof_gen_chk
  import usb_sof_pkg::*;
#(
  parameter int PERIOD_CYC = 5000
) (
  input logic               clk,
  input logic               rst_n,
  input logic               start_i,
  input logic               tick,
  input logic [FRAME_W-1:0] frame,
  input logic               pend,
  input logic [ADDR_W-1:0]  reg_addr_i,
  input logic [REG_W-1:0]   reg_rdata_o,
  input logic               irq_en_i,
  input logic               irq_o
);
  logic [31:0] gap_q;
  logic        seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q  <= '0;
      seen_q <= 1'b0;
    end else if (tick) begin
      gap_q  <= '0;
      seen_q <= 1'b1;
    end else if (seen_q) begin
      gap_q  <= gap_q + 32'd1;
    end
  end

  AST_FRAME_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> frame == $past(frame) + FRAME_W'(1)); // R2
  AST_FRAME_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(frame)); // R3
  AST_FRAME_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr_i == ADDR_FRAME) |-> (reg_rdata_o[31:16] == FRAME_TAG
      && reg_rdata_o[15:0] == 16'(frame))); // R4
  AST_PEND_SET: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> pend); // R5
  AST_PERIOD_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q && tick && !start_i) |-> gap_q == 32'(PERIOD_CYC - 1)); // R6
  AST_PERIOD_NO_LATE: assert property (@(posedge clk) disable iff (!rst_n)
    seen_q |-> gap_q < 32'(PERIOD_CYC)); // R6
  AST_IDLE_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (!seen_q && !start_i) |-> !tick); // R7
  AST_START_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |-> tick); // R7
  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en_i |-> !irq_o); // R8
endmodule

bind usb_sof_gen usb_sof_gen_chk #(.PERIOD_CYC(PERIOD_CYC)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start_i     (start_i),
  .tick        (sof_tick),
  .frame       (frame_q),
  .pend        (sof_pend),
  .reg_addr_i  (reg_addr_i),
  .reg_rdata_o (reg_rdata_o),
  .irq_en_i    (irq_en_i),
  .irq_o       (irq_o)
);

// File: tb/usb_sof_gen_bench.sv
module usb_sof_gen_bench;
  localparam int CLK_PERIOD = 10;
  localparam int P          = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic        reg_wr_i = 1'b0;
  logic [3:0]  reg_addr_i = 4'h0;
  logic [31:0] reg_wdata_i = '0;
  logic        irq_en_i = 1'b0;
  logic [31:0] reg_rdata_o;
  logic        irq_o;

  int n_vec = 0;
  int n_bad = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  usb_sof_gen #(.PERIOD_CYC(P)) u_usb_sof_gen (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .reg_wr_i(reg_wr_i),
    .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i),
    .reg_rdata_o(reg_rdata_o), .irq_en_i(irq_en_i), .irq_o(irq_o)
  );

  // behaviour model built from the requirements
  logic [13:0] m_frame;
  logic        m_pend;
  logic        m_run;
  int          m_cnt;
  always @(posedge clk) begin
    logic tk;
    if (!rst_n) begin
      m_frame <= '0; m_pend <= 1'b0; m_run <= 1'b0; m_cnt <= 0;
    end else begin
      tk = start_i || (m_run && m_cnt == P - 1);
      if (tk) begin
        m_frame <= m_frame + 14'd1; m_run <= 1'b1; m_cnt <= 0;
      end else if (m_run) begin
        m_cnt <= m_cnt + 1;
      end
      if (tk) m_pend <= 1'b1;
      else if (reg_wr_i && reg_addr_i == 4'h4 && reg_wdata_i[3]) m_pend <= 1'b0;
    end
  end

  function automatic logic [31:0] exp_read(logic [3:0] a, logic [13:0] f, logic p);
    if (a == 4'h0) return {16'h3210, 2'b00, f};
    if (a == 4'h4) return p ? 32'h8 : 32'h0;
    return 32'h0;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %08h expected %08h", req, act, exp);
    end
  endtask

  // compare outputs for the inputs of the last cycle, then drive new ones
  task automatic cyc(logic st, logic wr, logic [3:0] a, logic [31:0] d, logic en);
    @(negedge clk);
    chk("R4/R5/R9 read word", reg_rdata_o, exp_read(reg_addr_i, m_frame, m_pend));
    chk("R8 irq", 32'(irq_o), 32'(m_pend & irq_en_i));
    start_i = st; reg_wr_i = wr; reg_addr_i = a; reg_wdata_i = d; irq_en_i = en;
  endtask

  task automatic rd_chk(string req, logic [3:0] a, logic [31:0] exp);
    reg_addr_i = a;
    #1;
    chk(req, reg_rdata_o, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    logic [13:0] f0;
    logic [13:0] prev;
    logic [3:0]  addrs [4] = '{4'h0, 4'h4, 4'h8, 4'hC};
    void'($urandom(32'h5EED));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state, and R7: no tick before the first start
    repeat (P * 3) cyc(1'b0, 1'b0, 4'h0, '0, 1'b1);
    rd_chk("R1 frame word after reset", 4'h0, 32'h3210_0000);
    rd_chk("R1 status after reset", 4'h4, 32'h0);
    chk("R1 irq after reset", 32'(irq_o), 32'h0);

    // R3: write to frame word while idle
    cyc(1'b0, 1'b1, 4'h0, 32'hFFFF_FFFF, 1'b1);
    cyc(1'b0, 1'b0, 4'h0, '0, 1'b1);
    rd_chk("R3 frame after write", 4'h0, 32'h3210_0000);

    // R7 then R6: start ticks at once, next tick P cycles later
    cyc(1'b1, 1'b0, 4'h0, '0, 1'b1);
    cyc(1'b0, 1'b0, 4'h0, '0, 1'b1);
    rd_chk("R7 frame after start", 4'h0, 32'h3210_0001);
    chk("R8 irq after tick", 32'(irq_o), 32'h1);
    repeat (P - 1) cyc(1'b0, 1'b0, 4'h0, '0, 1'b1);
    rd_chk("R6 frame before period", 4'h0, 32'h3210_0001);
    cyc(1'b0, 1'b0, 4'h0, '0, 1'b1);
    rd_chk("R6 frame at period", 4'h0, 32'h3210_0002);

    // R5: clear with bit 3 low keeps, with bit 3 high clears
    cyc(1'b0, 1'b1, 4'h4, 32'hFFFF_FFF7, 1'b1);
    cyc(1'b0, 1'b0, 4'h4, '0, 1'b1);
    rd_chk("R5 pending kept", 4'h4, 32'h8);
    cyc(1'b0, 1'b1, 4'h4, 32'h0000_0008, 1'b1);
    cyc(1'b0, 1'b0, 4'h4, '0, 1'b1);
    rd_chk("R5 pending cleared", 4'h4, 32'h0);
    // R5: start and clear in the same cycle, set wins
    cyc(1'b1, 1'b1, 4'h4, 32'h0000_0008, 1'b1);
    cyc(1'b0, 1'b0, 4'h4, '0, 1'b0);
    rd_chk("R5 set wins over clear", 4'h4, 32'h8);
    chk("R8 irq masked", 32'(irq_o), 32'h0);

    // R9: unmapped write and read
    rd_chk("R9 read before", 4'h0, exp_read(4'h0, m_frame, m_pend));
    f0 = reg_rdata_o[13:0];
    cyc(1'b0, 1'b1, 4'hC, 32'hFFFF_FFFF, 1'b1);
    cyc(1'b0, 1'b0, 4'h8, '0, 1'b1);
    rd_chk("R9 unmapped read zero", 4'h8, 32'h0);
    rd_chk("R9 status kept", 4'h4, 32'h8);

    // R2: held start ticks every cycle through a full wrap
    prev = m_frame;
    for (int i = 0; i < 16400; i++) begin
      cyc(1'b1, 1'b0, 4'h0, '0, 1'b1);
      if (prev == 14'h3FFF) chk("R2 wrap to zero", 32'(reg_rdata_o[13:0]), 32'h0);
      prev = reg_rdata_o[13:0];
    end

    // random mix
    for (int i = 0; i < 4000; i++) begin
      cyc(($urandom % 40) == 0, ($urandom % 4) == 0, addrs[$urandom % 4],
          $urandom, $urandom % 2);
    end
    cyc(1'b0, 1'b0, 4'h0, '0, 1'b0);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule